// File: doc/BRIEF.md
# Four-Slot Long-Word Execution Core

This core runs programs made of 96-bit instruction words. Each word holds four 24-bit operation fields, and each field belongs to one fixed functional unit. Slots 0 and 1 feed two load/store units, slot 2 feeds a multiplier and slot 3 feeds an adder. All four operations in a word issue in the same cycle. They read their operands from one shared 16-entry register file that has eight read ports and four write ports, and they write back at the end of that cycle. The load/store slots reach a small local data memory while the multiplier and the adder are working. The hardware performs no dependency checking. The program's static schedule is trusted to order dependent work across words.

A host writes words into the instruction array through a program port and then pulses `go_i`. Fetch starts at word 0 and advances one word per cycle until a halt in slot 0. At that point `done_o` rises and stays high until the next `go_i`. A debug read port shows any register, so the host can collect results.

Slot field layout, with bit 0 as the slot's least significant bit: opcode [23:20], destination register [19:16], first source [15:12], second source [11:8], 8-bit immediate [7:0]. Slot k occupies word bits [24k+23:24k].

Opcodes:

| Code | Name | Meaning |
|------|------|---------|
| 0 | NOP | Does nothing. |
| 1 | LD | Destination = mem[(src1 + imm) mod memory depth]. |
| 2 | ST | mem[(src1 + imm) mod memory depth] = src2. |
| 3 | MUL | Destination = low 16 bits of src1 × src2. |
| 4 | ADD | Destination = src1 + src2, modulo 2^16. |
| 5 | ADDI | Destination = src1 + zero-extended imm. |
| 15 | HALT | Only valid in slot 0. |

Top module: `vliw_core`

## Requirements
- R1: After reset `done_o` is 0, every register reads 0 and the core is idle. No word executes and no register changes until `go_i` is pulsed, even when words are already loaded.
- R2: A `go_i` pulse starts fetch at word 0, and the core executes one word per cycle. `done_o` is first seen high H+1 cycles after the cycle that sampled `go_i`, where H is the index of the halting word.
- R3: A slot acts only on the opcodes of its own unit and treats every other code as NOP. Slots 0 and 1 accept LD and ST. Slot 2 accepts MUL. Slot 3 accepts ADD and ADDI. Codes 6 to 14 do nothing in any slot, and code 15 does nothing outside slot 0.
- R4: Every slot reads the register values from before its word began, so a result written by one slot is not seen by another slot in the same word.
- R5: When several slots write the same register in one word, the highest-numbered slot's value is kept. When both load/store slots store to the same address in one word, slot 1's data is kept.
- R6: The address for LD and ST is (src1 + imm) mod 64. A load that shares a word with a store to the same address returns the value from before the store.
- R7: MUL keeps the low 16 bits of the product, ADD wraps modulo 2^16, and ADDI adds the zero-extended immediate. Random programs built from all opcodes in all slots leave every register equal to a model built on R3 to R7.
- R8: A word with HALT (code 15) in slot 0 has no other effect: its other slots are suppressed. After it, `done_o` stays high and the registers stay unchanged until the next `go_i`.
- R9: The dot product y = a1·x1 + a2·x2 + a3·x3 takes 5 compute words. With a = 3, 7, 13 and x = 5, 11, 17 stored at data addresses 0 to 5, the program leaves 313 in register 1 and raises `done_o` 6 cycles after go.
- R10: `go_i` while `done_o` is high clears `done_o` on the next cycle and restarts fetch at word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start or restart execution at word 0 |
| prog_we_i | input | 1 | Write strobe for the instruction array |
| prog_addr_i | input | 5 | Instruction array word address |
| prog_wdata_i | input | 96 | Instruction word to store |
| dbg_addr_i | input | 4 | Register index for the debug read |
| dbg_data_o | output | 16 | Current contents of the selected register |
| done_o | output | 1 | High once a halt word has executed |

## Verification
A wrong fetch counter or a wrong halt decode shows up as a `done_o` edge in a cycle other than H+1 after go. That mismatch is visible in the first run. A wrong slot decode, write-port priority or memory-port priority corrupts a register or a memory word within one word, and the damage stays in the register file. A load that reads the bad memory word carries the error into a register. Every register is read back and compared after every program, including random programs. Read-before-write errors inside a word appear as a wrong operand in that same word's destination register.

// File: rtl/vliw_pkg.sv
`timescale 1ns/1ps
package vliw_pkg;
    localparam int NSLOT  = 4;
    localparam int NLSU   = 2;
    localparam int OP_W   = 4;
    localparam int RIDX_W = 4;
    localparam int IMM_W  = 8;
    localparam int SLOT_W = OP_W + 3 * RIDX_W + IMM_W;
    localparam int WORD_W = NSLOT * SLOT_W;
    localparam int NREG   = 1 << RIDX_W;

    localparam logic [OP_W-1:0] OP_NOP  = 4'd0;
    localparam logic [OP_W-1:0] OP_LD   = 4'd1;
    localparam logic [OP_W-1:0] OP_ST   = 4'd2;
    localparam logic [OP_W-1:0] OP_MUL  = 4'd3;
    localparam logic [OP_W-1:0] OP_ADD  = 4'd4;
    localparam logic [OP_W-1:0] OP_ADDI = 4'd5;
    localparam logic [OP_W-1:0] OP_HALT = 4'd15;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rs2;
        logic [IMM_W-1:0]  imm;
    } slot_t;
endpackage

// File: rtl/vliw_regfile.sv
`timescale 1ns/1ps
module vliw_regfile import vliw_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int NRD    = 8,
    parameter int NWR    = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [RIDX_W-1:0] raddr_i [NRD],
    output logic [DATA_W-1:0] rdata_o [NRD],
    input  logic [NWR-1:0]    wen_i,
    input  logic [RIDX_W-1:0] waddr_i [NWR],
    input  logic [DATA_W-1:0] wdata_i [NWR],
    input  logic [RIDX_W-1:0] dbg_addr_i,
    output logic [DATA_W-1:0] dbg_data_o
);
    logic [DATA_W-1:0] regs_d [NREG];
    logic [DATA_W-1:0] regs_q [NREG];

    // ascending port order: the highest-numbered writer lands last
    always_comb begin
        regs_d = regs_q;
        for (int p = 0; p < NWR; p++) begin
            if (wen_i[p]) regs_d[waddr_i[p]] = wdata_i[p];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int k = 0; k < NREG; k++) regs_q[k] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata_o[r] = regs_q[raddr_i[r]];
    end
    assign dbg_data_o = regs_q[dbg_addr_i];

    // R5
    top_writer_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wen_i[NWR-1] |=> regs_q[$past(waddr_i[NWR-1])] == $past(wdata_i[NWR-1]));
endmodule

// File: rtl/vliw_dmem.sv
`timescale 1ns/1ps
module vliw_dmem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int NPORT  = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [AW-1:0]     addr_i  [NPORT],
    input  logic [NPORT-1:0]  we_i,
    input  logic [DATA_W-1:0] wdata_i [NPORT],
    output logic [DATA_W-1:0] rdata_o [NPORT]
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int p = 0; p < NPORT; p++) begin
            if (we_i[p]) mem_d[addr_i[p]] = wdata_i[p];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rdata_o[p] = mem_q[addr_i[p]];
    end

    // R5
    store_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i[NPORT-1] |=> mem_q[$past(addr_i[NPORT-1])] == $past(wdata_i[NPORT-1]));
endmodule

// File: rtl/vliw_lsu_slot.sv
`timescale 1ns/1ps
module vliw_lsu_slot import vliw_pkg::*; #(
    parameter int DATA_W  = 16,
    parameter int MADDR_W = 6
) (
    input  logic [OP_W-1:0]    op_i,
    input  logic [RIDX_W-1:0]  rd_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic               issue_i,
    input  logic [DATA_W-1:0]  base_i,
    input  logic [DATA_W-1:0]  store_i,
    input  logic [DATA_W-1:0]  ld_data_i,
    output logic               rf_we_o,
    output logic [RIDX_W-1:0]  rf_waddr_o,
    output logic [DATA_W-1:0]  rf_wdata_o,
    output logic [MADDR_W-1:0] mem_addr_o,
    output logic               mem_we_o,
    output logic [DATA_W-1:0]  mem_wdata_o
);
    logic [DATA_W-1:0] ea;

    always_comb begin
        ea          = base_i + DATA_W'(imm_i);
        mem_addr_o  = ea[MADDR_W-1:0];
        mem_wdata_o = store_i;
        rf_waddr_o  = rd_i;
        rf_wdata_o  = ld_data_i;
        rf_we_o     = 1'b0;
        mem_we_o    = 1'b0;
        if (issue_i) begin
            case (op_i)
                OP_LD:   rf_we_o  = 1'b1;
                OP_ST:   mem_we_o = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vliw_alu_slot.sv
`timescale 1ns/1ps
module vliw_alu_slot import vliw_pkg::*; #(
    parameter int DATA_W = 16,
    parameter bit IS_MUL = 1'b0
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [RIDX_W-1:0] rd_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              rf_we_o,
    output logic [RIDX_W-1:0] rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);
    always_comb begin
        rf_we_o    = 1'b0;
        rf_waddr_o = rd_i;
        rf_wdata_o = '0;
        if (issue_i) begin
            case (op_i)
                OP_MUL: if (IS_MUL) begin
                    rf_we_o    = 1'b1;
                    rf_wdata_o = DATA_W'(a_i * b_i);
                end
                OP_ADD: if (!IS_MUL) begin
                    rf_we_o    = 1'b1;
                    rf_wdata_o = a_i + b_i;
                end
                OP_ADDI: if (!IS_MUL) begin
                    rf_we_o    = 1'b1;
                    rf_wdata_o = a_i + DATA_W'(imm_i);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vliw_core.sv
`timescale 1ns/1ps
module vliw_core import vliw_pkg::*; #(
    parameter int DATA_W     = 16,
    parameter int IMEM_DEPTH = 32,
    parameter int DMEM_DEPTH = 64,
    localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic              prog_we_i,
    input  logic [PC_W-1:0]   prog_addr_i,
    input  logic [WORD_W-1:0] prog_wdata_i,
    input  logic [RIDX_W-1:0] dbg_addr_i,
    output logic [DATA_W-1:0] dbg_data_o,
    output logic              done_o
);
    localparam int MADDR_W = $clog2(DMEM_DEPTH);
    localparam int NRD     = 2 * NSLOT;
    localparam int NWR     = NSLOT;

    typedef struct packed {
        logic            run;
        logic            done;
        logic [PC_W-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [WORD_W-1:0] imem_q [IMEM_DEPTH];
    logic [WORD_W-1:0] word;
    slot_t             slots [NSLOT];
    logic              halt, issue;

    logic [RIDX_W-1:0] rf_raddr [NRD];
    logic [DATA_W-1:0] rf_rdata [NRD];
    logic [NWR-1:0]    rf_wen;
    logic [RIDX_W-1:0] rf_waddr [NWR];
    logic [DATA_W-1:0] rf_wdata [NWR];

    logic [MADDR_W-1:0] dm_addr  [NLSU];
    logic [NLSU-1:0]    dm_we;
    logic [DATA_W-1:0]  dm_wdata [NLSU];
    logic [DATA_W-1:0]  dm_rdata [NLSU];

    always_ff @(posedge clk_i) begin
        if (prog_we_i) imem_q[prog_addr_i] <= prog_wdata_i;
    end

    always_comb begin
        word = imem_q[st_q.pc];
        for (int i = 0; i < NSLOT; i++) begin
            slots[i]          = word[i*SLOT_W +: SLOT_W];
            rf_raddr[2*i]     = slots[i].rs1;
            rf_raddr[2*i + 1] = slots[i].rs2;
        end
        halt  = st_q.run && (slots[0].op == OP_HALT);
        issue = st_q.run && !halt;
    end

    always_comb begin
        st_d = st_q;
        if (go_i) begin
            st_d.run  = 1'b1;
            st_d.done = 1'b0;
            st_d.pc   = '0;
        end else if (halt) begin
            st_d.run  = 1'b0;
            st_d.done = 1'b1;
        end else if (st_q.run) begin
            st_d.pc   = PC_W'(st_q.pc + 1'b1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o = st_q.done;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i < NLSU) begin : g_lsu
            vliw_lsu_slot #(.DATA_W(DATA_W), .MADDR_W(MADDR_W)) u_lsu (
                .op_i        (slots[i].op),
                .rd_i        (slots[i].rd),
                .imm_i       (slots[i].imm),
                .issue_i     (issue),
                .base_i      (rf_rdata[2*i]),
                .store_i     (rf_rdata[2*i + 1]),
                .ld_data_i   (dm_rdata[i]),
                .rf_we_o     (rf_wen[i]),
                .rf_waddr_o  (rf_waddr[i]),
                .rf_wdata_o  (rf_wdata[i]),
                .mem_addr_o  (dm_addr[i]),
                .mem_we_o    (dm_we[i]),
                .mem_wdata_o (dm_wdata[i])
            );
        end else begin : g_alu
            vliw_alu_slot #(.DATA_W(DATA_W), .IS_MUL(i == NLSU)) u_alu (
                .op_i       (slots[i].op),
                .rd_i       (slots[i].rd),
                .imm_i      (slots[i].imm),
                .issue_i    (issue),
                .a_i        (rf_rdata[2*i]),
                .b_i        (rf_rdata[2*i + 1]),
                .rf_we_o    (rf_wen[i]),
                .rf_waddr_o (rf_waddr[i]),
                .rf_wdata_o (rf_wdata[i])
            );
        end
    end

    vliw_regfile #(.DATA_W(DATA_W), .NRD(NRD), .NWR(NWR)) u_rf (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .raddr_i    (rf_raddr),
        .rdata_o    (rf_rdata),
        .wen_i      (rf_wen),
        .waddr_i    (rf_waddr),
        .wdata_i    (rf_wdata),
        .dbg_addr_i (dbg_addr_i),
        .dbg_data_o (dbg_data_o)
    );

    vliw_dmem #(.DATA_W(DATA_W), .DEPTH(DMEM_DEPTH), .NPORT(NLSU)) u_dm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (dm_addr),
        .we_i    (dm_we),
        .wdata_i (dm_wdata),
        .rdata_o (dm_rdata)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.run |-> (rf_wen == '0 && dm_we == '0));
    // R2
    pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && !halt && !go_i) |=> st_q.pc == PC_W'($past(st_q.pc) + 1'b1));
    // R8
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !go_i) |=> done_o);
    // R8
    pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !go_i) |=> $stable(st_q.pc));
    // R10
    go_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |=> (st_q.pc == '0 && st_q.run && !done_o));
endmodule

// File: tb/tb_vliw_core.sv
`timescale 1ns/1ps
module tb_vliw_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        prog_we = 1'b0;
    logic [4:0]  prog_addr = '0;
    logic [95:0] prog_wdata = '0;
    logic [3:0]  dbg_addr = '0;
    logic [15:0] dbg_data;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int seed_v;

    logic [15:0] m_reg [16];
    logic [15:0] m_mem [64];
    logic [95:0] prog_buf [32];
    int          prog_len;

    localparam logic [23:0] NOPS = 24'h0;

    vliw_core dut (
        .clk_i(clk), .rst_ni(rst_n), .go_i(go),
        .prog_we_i(prog_we), .prog_addr_i(prog_addr), .prog_wdata_i(prog_wdata),
        .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data), .done_o(done)
    );

    always #2.5 clk = ~clk;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R2 watchdog: actual %0d cycles expected fewer than 100000", cyc);
            report();
            $finish;
        end
    end

    function automatic logic [23:0] sl(input logic [3:0] op, input logic [3:0] rd,
                                       input logic [3:0] rs1, input logic [3:0] rs2,
                                       input logic [7:0] imm);
        return {op, rd, rs1, rs2, imm};
    endfunction

    function automatic logic [95:0] wd(input logic [23:0] s0, input logic [23:0] s1,
                                       input logic [23:0] s2, input logic [23:0] s3);
        return {s3, s2, s1, s0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Executes one word on the bench model; reports whether it halts.
    task automatic model_word(input logic [95:0] w, output bit halted);
        logic [15:0] nr [16];
        logic [15:0] nm [64];
        nr = m_reg;
        nm = m_mem;
        halted = (w[23:20] == 4'd15);
        if (!halted) begin
            for (int s = 0; s < 4; s++) begin
                logic [23:0] f;
                logic [3:0]  op, rd, rs1, rs2;
                logic [7:0]  imm;
                logic [15:0] a, b, ea;
                f   = w[24*s +: 24];
                op  = f[23:20]; rd = f[19:16]; rs1 = f[15:12]; rs2 = f[11:8]; imm = f[7:0];
                a   = m_reg[rs1];
                b   = m_reg[rs2];
                ea  = a + {8'h00, imm};
                if (s < 2) begin
                    if (op == 4'd1) nr[rd] = m_mem[ea[5:0]];
                    else if (op == 4'd2) nm[ea[5:0]] = b;
                end else if (s == 2) begin
                    if (op == 4'd3) nr[rd] = a * b;
                end else begin
                    if (op == 4'd4) nr[rd] = a + b;
                    else if (op == 4'd5) nr[rd] = a + {8'h00, imm};
                end
            end
        end
        m_reg = nr;
        m_mem = nm;
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < 16; r++) begin
            dbg_addr = r[3:0];
            #0.5;
            check($sformatf("%s reg %0d", tag, r), {16'h0, dbg_data}, {16'h0, m_reg[r]});
        end
    endtask

    task automatic load_prog();
        for (int i = 0; i < prog_len; i++) begin
            @(negedge clk);
            prog_we    = 1'b1;
            prog_addr  = i[4:0];
            prog_wdata = prog_buf[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic start_and_wait(input string tag, input int exp_cycles);
        int n;
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check({tag, " R10 done cleared after go"}, {31'h0, done}, 32'd0);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check({tag, " R2 cycles to done"}, n, exp_cycles);
    endtask

    task automatic run_prog(input string tag);
        int  exp_cycles;
        bit  h;
        load_prog();
        exp_cycles = 0;
        for (int i = 0; i < prog_len; i++) begin
            model_word(prog_buf[i], h);
            if (h) begin
                exp_cycles = i + 1;
                break;
            end
        end
        start_and_wait(tag, exp_cycles);
        check_regs(tag);
    endtask

    function automatic logic [23:0] rnd_slot(input int s);
        int pick;
        logic [3:0] op;
        pick = $urandom % 8;
        if (pick < 6)       op = pick[3:0];
        else if (pick == 6) op = 4'd7;
        else                op = (s == 0) ? 4'd0 : 4'd15;
        return sl(op, 4'($urandom % 16), 4'($urandom % 16), 4'($urandom % 16), 8'($urandom % 256));
    endfunction

    initial begin
        seed_v = $urandom(32'h5eed);
        for (int r = 0; r < 16; r++) m_reg[r] = '0;
        for (int k = 0; k < 64; k++) m_mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 done after reset", {31'h0, done}, 32'd0);
        check_regs("R1 reset");

        // Setup: put a1 x1 a2 x2 a3 x3 at addresses 0..5
        prog_buf[0] = wd(NOPS, NOPS, NOPS, sl(4'd5, 4'd1, 4'd0, 4'd0, 8'd3));
        prog_buf[1] = wd(NOPS, NOPS, NOPS, sl(4'd5, 4'd2, 4'd0, 4'd0, 8'd5));
        prog_buf[2] = wd(NOPS, NOPS, NOPS, sl(4'd5, 4'd3, 4'd0, 4'd0, 8'd7));
        prog_buf[3] = wd(NOPS, NOPS, NOPS, sl(4'd5, 4'd4, 4'd0, 4'd0, 8'd11));
        prog_buf[4] = wd(NOPS, NOPS, NOPS, sl(4'd5, 4'd5, 4'd0, 4'd0, 8'd13));
        prog_buf[5] = wd(NOPS, NOPS, NOPS, sl(4'd5, 4'd6, 4'd0, 4'd0, 8'd17));
        prog_buf[6] = wd(sl(4'd2, 4'd0, 4'd0, 4'd1, 8'd0), sl(4'd2, 4'd0, 4'd0, 4'd2, 8'd1), NOPS, NOPS);
        prog_buf[7] = wd(sl(4'd2, 4'd0, 4'd0, 4'd3, 8'd2), sl(4'd2, 4'd0, 4'd0, 4'd4, 8'd3), NOPS, NOPS);
        prog_buf[8] = wd(sl(4'd2, 4'd0, 4'd0, 4'd5, 8'd4), sl(4'd2, 4'd0, 4'd0, 4'd6, 8'd5), NOPS, NOPS);
        prog_buf[9] = wd(sl(4'd15, 4'd0, 4'd0, 4'd0, 8'd0), NOPS, NOPS, NOPS);
        prog_len = 10;

        // R1: loaded but not started, nothing changes
        load_prog();
        repeat (8) @(negedge clk);
        check("R1 idle done", {31'h0, done}, 32'd0);
        check_regs("R1 idle before go");

        run_prog("R6 R7 setup");

        // R9: reference dot product
        prog_buf[0] = wd(sl(4'd1, 4'd7, 4'd0, 4'd0, 8'd0), sl(4'd1, 4'd8, 4'd0, 4'd0, 8'd1), NOPS, NOPS);
        prog_buf[1] = wd(sl(4'd1, 4'd9, 4'd0, 4'd0, 8'd2), sl(4'd1, 4'd10, 4'd0, 4'd0, 8'd3),
                         sl(4'd3, 4'd11, 4'd7, 4'd8, 8'd0), NOPS);
        prog_buf[2] = wd(sl(4'd1, 4'd12, 4'd0, 4'd0, 8'd4), sl(4'd1, 4'd13, 4'd0, 4'd0, 8'd5),
                         sl(4'd3, 4'd14, 4'd9, 4'd10, 8'd0), NOPS);
        prog_buf[3] = wd(NOPS, NOPS, sl(4'd3, 4'd15, 4'd12, 4'd13, 8'd0), sl(4'd4, 4'd1, 4'd11, 4'd14, 8'd0));
        prog_buf[4] = wd(NOPS, NOPS, NOPS, sl(4'd4, 4'd1, 4'd1, 4'd15, 8'd0));
        prog_buf[5] = wd(sl(4'd15, 4'd0, 4'd0, 4'd0, 8'd0), NOPS, NOPS, NOPS);
        prog_len = 6;
        load_prog();
        begin
            bit h;
            for (int i = 0; i < 6; i++) model_word(prog_buf[i], h);
        end
        start_and_wait("R9 dot product", 6);
        dbg_addr = 4'd1;  #0.5; check("R9 y in r1", {16'h0, dbg_data}, 32'd313);
        dbg_addr = 4'd11; #0.5; check("R9 a1*x1", {16'h0, dbg_data}, 32'd15);
        dbg_addr = 4'd14; #0.5; check("R9 a2*x2", {16'h0, dbg_data}, 32'd77);
        dbg_addr = 4'd15; #0.5; check("R9 a3*x3", {16'h0, dbg_data}, 32'd221);
        check_regs("R9 all regs");

        // R4: same-word reads see old values
        prog_buf[0] = wd(sl(4'd1, 4'd2, 4'd0, 4'd0, 8'd0), NOPS,
                         sl(4'd3, 4'd4, 4'd2, 4'd3, 8'd0), sl(4'd4, 4'd3, 4'd2, 4'd2, 8'd0));
        prog_buf[1] = wd(sl(4'd15, 4'd0, 4'd0, 4'd0, 8'd0), NOPS, NOPS, NOPS);
        prog_len = 2;
        run_prog("R4 read before write");

        // R5: register and memory write conflicts
        prog_buf[0] = wd(sl(4'd1, 4'd5, 4'd0, 4'd0, 8'd1), sl(4'd1, 4'd5, 4'd0, 4'd0, 8'd2),
                         sl(4'd3, 4'd6, 4'd1, 4'd1, 8'd0), sl(4'd4, 4'd6, 4'd2, 4'd2, 8'd0));
        prog_buf[1] = wd(sl(4'd2, 4'd0, 4'd0, 4'd1, 8'd10), sl(4'd2, 4'd0, 4'd0, 4'd2, 8'd10), NOPS, NOPS);
        prog_buf[2] = wd(sl(4'd1, 4'd7, 4'd0, 4'd0, 8'd10), NOPS, NOPS, NOPS);
        prog_buf[3] = wd(sl(4'd15, 4'd0, 4'd0, 4'd0, 8'd0), NOPS, NOPS, NOPS);
        prog_len = 4;
        run_prog("R5 write priority");

        // R6: load beside store, address wrap
        prog_buf[0] = wd(sl(4'd2, 4'd0, 4'd0, 4'd3, 8'd11), sl(4'd1, 4'd8, 4'd0, 4'd0, 8'd11),
                         NOPS, sl(4'd5, 4'd13, 4'd0, 4'd0, 8'd200));
        prog_buf[1] = wd(sl(4'd2, 4'd0, 4'd13, 4'd4, 8'd100), NOPS, NOPS, NOPS);
        prog_buf[2] = wd(sl(4'd1, 4'd14, 4'd0, 4'd0, 8'd44), sl(4'd1, 4'd9, 4'd0, 4'd0, 8'd11), NOPS, NOPS);
        prog_buf[3] = wd(sl(4'd15, 4'd0, 4'd0, 4'd0, 8'd0), NOPS, NOPS, NOPS);
        prog_len = 4;
        run_prog("R6 addressing");

        // R3: opcodes outside a slot's unit do nothing
        prog_buf[0] = wd(sl(4'd3, 4'd9, 4'd1, 4'd2, 8'd0), sl(4'd4, 4'd9, 4'd1, 4'd2, 8'd0),
                         sl(4'd1, 4'd9, 4'd0, 4'd0, 8'd0), sl(4'd2, 4'd0, 4'd0, 4'd1, 8'd12));
        prog_buf[1] = wd(sl(4'd7, 4'd9, 4'd1, 4'd1, 8'd0), sl(4'd15, 4'd9, 4'd0, 4'd0, 8'd0),
                         sl(4'd5, 4'd9, 4'd0, 4'd0, 8'd5), sl(4'd3, 4'd9, 4'd1, 4'd1, 8'd0));
        prog_buf[2] = wd(sl(4'd1, 4'd10, 4'd0, 4'd0, 8'd12), sl(4'd9, 4'd10, 4'd1, 4'd1, 8'd3), NOPS, NOPS);
        prog_buf[3] = wd(sl(4'd15, 4'd0, 4'd0, 4'd0, 8'd0), NOPS, NOPS, NOPS);
        prog_len = 4;
        run_prog("R3 slot binding");
        dbg_addr = 4'd10; #0.5; check("R3 no stray store at 12", {16'h0, dbg_data}, 32'd0);

        // R8: halt word suppresses its other slots; state holds afterwards
        prog_buf[0] = wd(NOPS, NOPS, NOPS, sl(4'd5, 4'd12, 4'd0, 4'd0, 8'd1));
        prog_buf[1] = wd(sl(4'd15, 4'd0, 4'd0, 4'd0, 8'd0), sl(4'd1, 4'd11, 4'd0, 4'd0, 8'd1),
                         sl(4'd3, 4'd11, 4'd1, 4'd1, 8'd0), sl(4'd5, 4'd12, 4'd0, 4'd0, 8'd99));
        prog_buf[2] = wd(NOPS, NOPS, NOPS, sl(4'd5, 4'd12, 4'd0, 4'd0, 8'd77));
        prog_len = 3;
        run_prog("R8 halt word");
        repeat (10) @(negedge clk);
        check("R8 done held", {31'h0, done}, 32'd1);
        check_regs("R8 after halt");

        // R7: constrained random programs against the model
        for (int p = 0; p < 20; p++) begin
            for (int i = 0; i < 24; i++)
                prog_buf[i] = wd(rnd_slot(0), rnd_slot(1), rnd_slot(2), rnd_slot(3));
            prog_buf[24] = wd(sl(4'd15, 4'd0, 4'd0, 4'd0, 8'd0), rnd_slot(1), rnd_slot(2), rnd_slot(3));
            prog_len = 25;
            run_prog($sformatf("R7 random %0d", p));
        end

        report();
        $finish;
    end
endmodule